// File: doc/BRIEF.md
# Per-Bank Row Timing Tracker

This block sits beside the command scheduler of an SDRAM controller and keeps the row timing rules of a four-bank device. The scheduler tells it about every activate, read, write and precharge, with the target bank, as it issues them. For each bank the block keeps an open-row flag and a set of down-counters. From these it drives three per-bank ready vectors: a new activate may go out, a column command may go out, or a precharge may go out. The scheduler consults these vectors before it picks its next command.

All limits are given in picoseconds together with the clock period. The block turns them into whole cycles by rounding up, so one set of device figures serves any clock rate. A spacing between activates to different banks is shared by all banks. The block also flags a bank whose row has stayed open past the maximum active time. A command issued against a low ready signal has no effect on the bank state and sets a sticky violation flag.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset every bank is closed, `act_ok` is all ones, `col_ok`, `pre_ok`, `row_open` and `overdue` are all zeros, and `violation` is 0.
- R2: A command is sampled on a rising clock edge when `cmd_valid` is 1. `cmd_op` encodes 0 = activate, 1 = read, 2 = write, 3 = precharge. `cmd_bank` selects the bank, and bit n of every per-bank vector belongs to bank n. An accepted activate sets that bank's `row_open` bit, and an accepted precharge clears it.
- R3: If an activate is accepted at edge k, `col_ok` for that bank is 0 until it rises after edge k+RCD-1. A read or write is therefore accepted from edge k+RCD on.
- R4: If an activate is accepted at edge k, `pre_ok` for that bank rises after edge k+RASMIN-1 and not earlier.
- R5: After a precharge accepted at edge p, `act_ok` for that bank stays 0 through edge p+RP-1.
- R6: After an activate accepted at edge k, `act_ok` for the same bank stays 0 through edge k+RC-1, even when the precharge wait has already ended.
- R7: After any activate accepted at edge k, `act_ok` is 0 for every bank through edge k+RRD-1.
- R8: A precharge with `cmd_all` = 1 is accepted only if every open bank has `pre_ok` = 1. It closes all banks and starts the precharge wait on all of them.
- R9: A command whose ready condition is 0 leaves all bank state unchanged. It sets `violation`, which stays 1 until reset.
- R10: If a bank is opened at edge k and is not precharged, its `overdue` bit rises after edge k+RASMAX. The bit stays 1 until that bank is precharged.
- R11: Each cycle count is the picosecond limit divided by `CLK_PS`, rounded up. For example, 16 000 ps at 5 000 ps gives 4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_bank | input | 2 | Target bank |
| cmd_all | input | 1 | With a precharge, applies it to every bank |
| act_ok | output | 4 | Activate allowed, per bank |
| col_ok | output | 4 | Read or write allowed, per bank |
| pre_ok | output | 4 | Precharge allowed, per bank |
| row_open | output | 4 | Bank holds an open row |
| overdue | output | 4 | Row open longer than the maximum active time |
| violation | output | 1 | Sticky: an illegal command was seen |

## Verification
Two waits can end on the same edge: the precharge wait and the row cycle wait of one bank. The bench sets the row cycle longer than the sum of the minimum active time and the precharge wait. Bank 0 then shows `act_ok` still low for two cycles after its precharge wait has run out, which separates the two rules. The second coincidence is the cross-bank activate spacing landing on the same edges as a bank's own column wait. A read to bank 0 is issued on the edge where the spacing expires, and both `col_ok` and `act_ok` are compared each cycle against hand-derived vectors.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } bt_op_e;

    // round a picosecond limit up to whole clock cycles, never below one
    function automatic int cyc_of(input int lim_ps, input int clk_ps);
        int c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bt_gap.sv
module bt_gap #(
    parameter int GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic clear_o
);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) cnt_d = cnt_q - GW'(1);
        if (start_i)     cnt_d = GW'(GAP_CYC - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign clear_o = (cnt_q == '0);

endmodule

// File: rtl/bt_bank.sv
module bt_bank #(
    parameter int RCD_CYC     = 3,
    parameter int RAS_MIN_CYC = 7,
    parameter int RAS_MAX_CYC = 24000,
    parameter int RP_CYC      = 4,
    parameter int RC_CYC      = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    output logic act_ok_o,
    output logic col_ok_o,
    output logic pre_ok_o,
    output logic open_o,
    output logic overdue_o
);
    localparam int MAXC = bt_pkg::imax(bt_pkg::imax(RCD_CYC, RAS_MIN_CYC),
                          bt_pkg::imax(bt_pkg::imax(RAS_MAX_CYC, RP_CYC), RC_CYC));
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic          open;
        logic          late;
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras;
        logic [CW-1:0] rp;
        logic [CW-1:0] rc;
        logic [CW-1:0] tmax;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.rcd  = dn(st_q.rcd);
        st_d.ras  = dn(st_q.ras);
        st_d.rp   = dn(st_q.rp);
        st_d.rc   = dn(st_q.rc);
        st_d.tmax = dn(st_q.tmax);
        if (st_q.open && st_q.tmax == '0) st_d.late = 1'b1;
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.late = 1'b0;
            st_d.rcd  = CW'(RCD_CYC - 1);
            st_d.ras  = CW'(RAS_MIN_CYC - 1);
            st_d.rc   = CW'(RC_CYC - 1);
            st_d.tmax = CW'(RAS_MAX_CYC - 1);
        end else if (pre_i) begin
            st_d.open = 1'b0;
            st_d.late = 1'b0;
            st_d.rp   = CW'(RP_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_ok_o  = !st_q.open && st_q.rp == '0 && st_q.rc == '0;
    assign col_ok_o  = st_q.open && st_q.rcd == '0;
    assign pre_ok_o  = st_q.open && st_q.ras == '0;
    assign open_o    = st_q.open;
    assign overdue_o = st_q.late;

    // R3
    rcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RCD_CYC > 1 && act_i) |=> (open_o && !col_ok_o));
    // R4
    ras_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RAS_MIN_CYC > 1 && act_i) |=> !pre_ok_o);
    // R5
    rp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RP_CYC > 1 && pre_i) |=> (!open_o && !act_ok_o));
    // R10
    late_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overdue_o |-> open_o);

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker #(
    parameter int CLK_PS     = 5000,
    parameter int RCD_PS     = 15000,
    parameter int RAS_MIN_PS = 35000,
    parameter int RAS_MAX_PS = 120000000,
    parameter int RP_PS      = 16000,
    parameter int RC_PS      = 55000,
    parameter int RRD_PS     = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic [1:0] cmd_bank,
    input  logic       cmd_all,
    output logic [3:0] act_ok,
    output logic [3:0] col_ok,
    output logic [3:0] pre_ok,
    output logic [3:0] row_open,
    output logic [3:0] overdue,
    output logic       violation
);
    import bt_pkg::*;

    localparam int NB          = 4;
    localparam int RCD_CYC     = cyc_of(RCD_PS, CLK_PS);
    localparam int RAS_MIN_CYC = cyc_of(RAS_MIN_PS, CLK_PS);
    localparam int RAS_MAX_CYC = cyc_of(RAS_MAX_PS, CLK_PS);
    localparam int RP_CYC      = cyc_of(RP_PS, CLK_PS);
    localparam int RC_CYC      = cyc_of(RC_PS, CLK_PS);
    localparam int RRD_CYC     = cyc_of(RRD_PS, CLK_PS);

    typedef struct packed {
        logic viol;
    } top_st_t;

    top_st_t         st_d, st_q;
    bt_op_e          op;
    logic            legal;
    logic            accept;
    logic [NB-1:0]   sel;
    logic [NB-1:0]   act_go, pre_go;
    logic [NB-1:0]   bank_act_ok;
    logic            rrd_clear;

    assign op  = bt_op_e'(cmd_op);
    assign sel = NB'(1) << cmd_bank;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_ACT:       legal = act_ok[cmd_bank];
            OP_RD, OP_WR: legal = col_ok[cmd_bank];
            default:      legal = cmd_all ? (&(pre_ok | ~row_open))
                                          : pre_ok[cmd_bank];
        endcase
        accept = cmd_valid && legal;
        act_go = (accept && op == OP_ACT) ? sel : '0;
        pre_go = (accept && op == OP_PRE) ? (cmd_all ? '1 : sel) : '0;
        if (cmd_valid && !legal) st_d.viol = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bt_gap #(.GAP_CYC(RRD_CYC)) u_rrd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (|act_go),
        .clear_o (rrd_clear)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bt_bank #(
            .RCD_CYC     (RCD_CYC),
            .RAS_MIN_CYC (RAS_MIN_CYC),
            .RAS_MAX_CYC (RAS_MAX_CYC),
            .RP_CYC      (RP_CYC),
            .RC_CYC      (RC_CYC)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act_go[b]),
            .pre_i     (pre_go[b]),
            .act_ok_o  (bank_act_ok[b]),
            .col_ok_o  (col_ok[b]),
            .pre_ok_o  (pre_ok[b]),
            .open_o    (row_open[b]),
            .overdue_o (overdue[b])
        );
    end

    assign act_ok    = bank_act_ok & {NB{rrd_clear}};
    assign violation = st_q.viol;

    // R9
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
    // R9
    ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !legal) |=> ($stable(row_open) && violation));
    // R7
    rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RRD_CYC > 1 && (|act_go)) |=> (act_ok == '0));
    // R8
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PRE && cmd_all) |=> (row_open == '0));
    // R2
    one_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_go));

endmodule

// File: tb/bank_timing_tracker_test.sv
module bank_timing_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [1:0] cmd_bank;
    logic       cmd_all;
    logic [3:0] act_ok, col_ok, pre_ok, row_open, overdue;
    logic       violation;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    // cycles: RCD 3, RASmin 7, RP 4 (16 ns rounded up), RC 13, RRD 2, RASmax 20
    bank_timing_tracker #(
        .RC_PS      (65000),
        .RAS_MAX_PS (100000)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .cmd_all   (cmd_all),
        .act_ok    (act_ok),
        .col_ok    (col_ok),
        .pre_ok    (pre_ok),
        .row_open  (row_open),
        .overdue   (overdue),
        .violation (violation)
    );

    // {valid, op, bank, all, exp act_ok, exp col_ok, exp pre_ok, exp row_open}
    localparam int NV = 18;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 2'd0, 2'd0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0001},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b1110, 4'b0000, 4'b0000, 4'b0001},
        {1'b1, 2'd0, 2'd1, 1'b0, 4'b0000, 4'b0001, 4'b0000, 4'b0011},
        {1'b1, 2'd1, 2'd0, 1'b0, 4'b1100, 4'b0001, 4'b0000, 4'b0011},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b1100, 4'b0011, 4'b0000, 4'b0011},
        {1'b1, 2'd2, 2'd1, 1'b0, 4'b1100, 4'b0011, 4'b0000, 4'b0011},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b1100, 4'b0011, 4'b0001, 4'b0011},
        {1'b1, 2'd3, 2'd0, 1'b0, 4'b1100, 4'b0010, 4'b0000, 4'b0010},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b1100, 4'b0010, 4'b0010, 4'b0010},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b1100, 4'b0010, 4'b0010, 4'b0010},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b1100, 4'b0010, 4'b0010, 4'b0010},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b1100, 4'b0010, 4'b0010, 4'b0010},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b1101, 4'b0010, 4'b0010, 4'b0010},
        {1'b1, 2'd3, 2'd2, 1'b1, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {1'b0, 2'd0, 2'd0, 1'b0, 4'b1111, 4'b0000, 4'b0000, 4'b0000},
        {1'b1, 2'd0, 2'd2, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0100}
    };

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [1:0] op, input logic [1:0] bk,
                         input logic all);
        cmd_valid = v;
        cmd_op    = op;
        cmd_bank  = bk;
        cmd_all   = all;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_bank = 2'd0; cmd_all = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 act_ok", act_ok, 4'b1111);
        chk("R1 col_ok", col_ok, 4'b0000);
        chk("R1 pre_ok", pre_ok, 4'b0000);
        chk("R1 row_open", row_open, 4'b0000);
        chk("R1 overdue", overdue, 4'b0000);
        chk("R1 violation", {3'b0, violation}, 4'b0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][21], VEC[i][20:19], VEC[i][18:17], VEC[i][16]);
            chk("R5 R6 R7 R11 act_ok", act_ok, VEC[i][15:12]);
            chk("R3 col_ok", col_ok, VEC[i][11:8]);
            chk("R4 pre_ok", pre_ok, VEC[i][7:4]);
            chk("R2 R8 row_open", row_open, VEC[i][3:0]);
            chk("R9 no violation", {3'b0, violation}, 4'b0000);
        end

        // R10: bank 2 opened at edge 18, overdue after edge 38
        repeat (19) @(posedge clk);
        #1;
        chk("R10 not yet overdue", overdue, 4'b0000);
        @(posedge clk);
        #1;
        chk("R10 overdue raised", overdue, 4'b0100);
        chk("R10 still open", row_open, 4'b0100);
        issue(1'b1, 2'd3, 2'd2, 1'b0);
        chk("R10 overdue cleared", overdue, 4'b0000);
        chk("R2 closed by precharge", row_open, 4'b0000);

        // R9: read to a closed bank is refused
        issue(1'b1, 2'd1, 2'd2, 1'b0);
        chk("R9 violation set", {3'b0, violation}, 4'b0001);
        chk("R9 state untouched", row_open, 4'b0000);

        // R7 and R9: second activate inside the spacing is ignored
        issue(1'b1, 2'd0, 2'd3, 1'b0);
        chk("R7 first activate", row_open, 4'b1000);
        issue(1'b1, 2'd0, 2'd0, 1'b0);
        chk("R9 R7 ignored activate", row_open, 4'b1000);
        issue(1'b0, 2'd0, 2'd0, 1'b0);
        chk("R9 sticky violation", {3'b0, violation}, 4'b0001);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 reset act_ok", act_ok, 4'b1111);
        chk("R1 reset row_open", row_open, 4'b0000);
        chk("R1 reset violation", {3'b0, violation}, 4'b0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule